// File: doc/BRIEF.md
# Sample-Period Sequencer for a Sampled FIR Datapath

This block sets the pace of a sampled-signal filter. A free-running counter marks one sample instant per programmable number of clock cycles. At each instant the block runs a fixed chain of steps. First it sends the result of the previous period to the DAC. Next it writes the most recently converted ADC value into a small sample history. Then it starts the next ADC conversion, and only after that does it launch the convolution engine. It then waits for the engine to report completion and idles until the next instant. Because of this ordering, the conversion runs while the arithmetic runs, and the output stream is one sample behind the input stream.

The engine reads the history through an age-indexed port, so it never has to track a write pointer. If a sample instant arrives while a sequence is still running, a sticky overrun flag is raised. That one instant is kept pending and served as soon as the sequencer returns to idle.

Top module: `sample_period_seq`

## Requirements
- R1: With period value P (P of 0 acts as 1), a sample instant occurs whenever a counter that is cleared at reset and restarts at each instant has reached P-1. An instant that finds the sequencer idle makes dac_strobe_o go high in the next cycle.
- R2: After dac_strobe_o, the history write, adc_start_o and eng_start_o follow in the three next consecutive cycles, and no two of these four are ever active together.
- R3: dac_data_o changes only in the cycle in which dac_strobe_o goes high. It then shows the result captured at the end of the previous sequence, or 0 if no result has been captured since reset.
- R4: hist_data_o shows the stored sample selected by hist_idx_i, where index 0 is the newest sample and index k is the sample stored k sequences earlier. The history holds TAPS samples, and the oldest is dropped on each write.
- R5: The value written into the history is the adc_data_i value present at the most recent adc_ready_i pulse before the write cycle. If no such pulse has occurred, the value is 0.
- R6: dac_strobe_o, adc_start_o and eng_start_o are each exactly one clock cycle wide.
- R7: A sample instant that arrives while a sequence is running sets overrun_o, which stays set until reset. That instant is held, and dac_strobe_o rises two cycles after the cycle in which eng_done_i ends the sequence.
- R8: eng_result_i is captured only when eng_done_i is high while the sequencer waits for the engine. A done pulse at any other time has no effect on later DAC values.
- R9: While reset is asserted, every output is 0 and every history entry reads 0.
- R10: A period value of 0 behaves exactly like a period value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Sample period in clock cycles |
| adc_data_i | input | DW | Converted ADC value |
| adc_ready_i | input | 1 | Pulse: adc_data_i holds a finished conversion |
| adc_start_o | output | 1 | One-cycle start-of-conversion pulse |
| dac_data_o | output | RW | Value held for the DAC |
| dac_strobe_o | output | 1 | One-cycle DAC write strobe |
| eng_start_o | output | 1 | One-cycle convolution launch pulse |
| eng_done_i | input | 1 | Convolution finished, result valid |
| eng_result_i | input | RW | Convolution result |
| hist_idx_i | input | IDX_W | Age index into the history (0 = newest) |
| hist_data_o | output | DW | History entry selected by hist_idx_i |
| overrun_o | output | 1 | Sticky: an instant arrived during a sequence |

## Verification
A state register that skips or repeats a step shows up at the strobe ports within a single cycle. It appears as a pulse two cycles wide, a missing adc_start_o, or an eng_start_o that comes before the conversion start. A bad period count or a lost pending instant shifts the next dac_strobe_o by at least one cycle, and this is visible at the very next sample instant. A wrong write pointer or capture value in the history shows on hist_data_o within the same sequence. A wrong result capture shows on dac_data_o only one full period later, because the output is deliberately delayed by one sample.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_WAIT = 3'd0,
    ST_OUTPUT    = 3'd1,
    ST_STORE     = 3'd2,
    ST_START_ADC = 3'd3,
    ST_RUN_FIR   = 3'd4,
    ST_WAIT_DONE = 3'd5
  } seq_state_e;

  // Step order of one sample period; WAIT_DONE leaves only on engine done.
  function automatic seq_state_e seq_next(seq_state_e s, logic go, logic done);
    case (s)
      ST_IDLE_WAIT: return go ? ST_OUTPUT : ST_IDLE_WAIT;
      ST_OUTPUT:    return ST_STORE;
      ST_STORE:     return ST_START_ADC;
      ST_START_ADC: return ST_RUN_FIR;
      ST_RUN_FIR:   return ST_WAIT_DONE;
      ST_WAIT_DONE: return done ? ST_IDLE_WAIT : ST_WAIT_DONE;
      default:      return ST_IDLE_WAIT;
    endcase
  endfunction

endpackage

// File: rtl/period_timer.sv
module period_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);

  // Terminal count for a period; zero is treated as a period of one.
  function automatic logic [CNT_W-1:0] last_count(logic [CNT_W-1:0] p);
    return (p == '0) ? '0 : p - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= last_count(period_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/sample_history.sv
module sample_history #(
  parameter int DW   = 12,
  parameter int TAPS = 16,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [DW-1:0]    rdata_o
);

  // Physical slot of the sample that is 'age' writes old.
  function automatic logic [IDX_W-1:0] slot_of(logic [IDX_W-1:0] wp, logic [IDX_W-1:0] age);
    return wp - IDX_W'(1) - age;
  endfunction

  logic [IDX_W-1:0] wptr_q;
  logic [DW-1:0]    mem_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wptr_q <= '0;
    else if (we_i) wptr_q <= wptr_q + IDX_W'(1);
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[t] <= '0;
      else if (we_i && wptr_q == IDX_W'(t))   mem_q[t] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[slot_of(wptr_q, idx_i)];

endmodule

// File: rtl/sequencer_fsm.sv
module sequencer_fsm
  import sps_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic eng_done_i,
  output logic dac_strobe_o,
  output logic hist_we_o,
  output logic adc_start_o,
  output logic eng_start_o,
  output logic res_cap_o,
  output logic seq_go_o,
  output logic late_tick_o,
  output logic idle_o,
  output logic overrun_o
);

  seq_state_e state_q;
  logic       pend_q;
  logic       ovr_q;

  assign idle_o      = (state_q == ST_IDLE_WAIT);
  assign seq_go_o    = idle_o && (tick_i || pend_q);
  assign late_tick_o = tick_i && !idle_o;
  assign res_cap_o   = (state_q == ST_WAIT_DONE) && eng_done_i;

  assign dac_strobe_o = (state_q == ST_OUTPUT);
  assign hist_we_o    = (state_q == ST_STORE);
  assign adc_start_o  = (state_q == ST_START_ADC);
  assign eng_start_o  = (state_q == ST_RUN_FIR);
  assign overrun_o    = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE_WAIT;
      pend_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= seq_next(state_q, seq_go_o, eng_done_i);
      if (late_tick_o) begin
        pend_q <= 1'b1;
        ovr_q  <= 1'b1;
      end else if (seq_go_o) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sample_period_seq.sv
module sample_period_seq #(
  parameter int CNT_W = 16,
  parameter int DW    = 12,
  parameter int RW    = 16,
  parameter int TAPS  = 16,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DW-1:0]    adc_data_i,
  input  logic             adc_ready_i,
  output logic             adc_start_o,
  output logic [RW-1:0]    dac_data_o,
  output logic             dac_strobe_o,
  output logic             eng_start_o,
  input  logic             eng_done_i,
  input  logic [RW-1:0]    eng_result_i,
  input  logic [IDX_W-1:0] hist_idx_i,
  output logic [DW-1:0]    hist_data_o,
  output logic             overrun_o
);

  logic tick, seq_go, late_tick, hist_we, res_cap, idle;

  logic [DW-1:0] adc_cap_q;
  logic [RW-1:0] result_q;
  logic [RW-1:0] dac_q;

  period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .tick_o   (tick)
  );

  sequencer_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .eng_done_i   (eng_done_i),
    .dac_strobe_o (dac_strobe_o),
    .hist_we_o    (hist_we),
    .adc_start_o  (adc_start_o),
    .eng_start_o  (eng_start_o),
    .res_cap_o    (res_cap),
    .seq_go_o     (seq_go),
    .late_tick_o  (late_tick),
    .idle_o       (idle),
    .overrun_o    (overrun_o)
  );

  sample_history #(.DW(DW), .TAPS(TAPS)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hist_we),
    .wdata_i (adc_cap_q),
    .idx_i   (hist_idx_i),
    .rdata_o (hist_data_o)
  );

  // Holds the latest finished conversion until the store step takes it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          adc_cap_q <= '0;
    else if (adc_ready_i) adc_cap_q <= adc_data_i;
  end

  // Result of this period waits here and leaves at the next sample instant.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      dac_q    <= '0;
    end else begin
      if (res_cap) result_q <= eng_result_i;
      if (seq_go)  dac_q    <= result_q;
    end
  end

  assign dac_data_o = dac_q;

endmodule

// File: rtl/sample_period_seq_chk.sv
module sample_period_seq_chk #(
  parameter int RW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          seq_go,
  input logic          late_tick,
  input logic          hist_we,
  input logic          res_cap,
  input logic          idle,
  input logic          dac_strobe_o,
  input logic          adc_start_o,
  input logic          eng_start_o,
  input logic          overrun_o,
  input logic [RW-1:0] dac_data_o,
  input logic [RW-1:0] result_q
);

  p_go_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_go |=> dac_strobe_o);

  p_go_from_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_go |-> idle);

  p_store_after_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_strobe_o |=> hist_we);

  p_conv_after_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_we |=> adc_start_o);

  p_eng_after_conv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> eng_start_o);

  p_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dac_strobe_o, hist_we, adc_start_o, eng_start_o}));

  p_dac_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_strobe_o |-> $stable(dac_data_o));

  p_dac_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_strobe_o |=> !dac_strobe_o);

  p_adc_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  p_eng_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  p_late_sets_ovr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_tick |=> overrun_o);

  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_cap |=> $stable(result_q));

endmodule

bind sample_period_seq sample_period_seq_chk #(.RW(RW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .seq_go       (seq_go),
  .late_tick    (late_tick),
  .hist_we      (hist_we),
  .res_cap      (res_cap),
  .idle         (idle),
  .dac_strobe_o (dac_strobe_o),
  .adc_start_o  (adc_start_o),
  .eng_start_o  (eng_start_o),
  .overrun_o    (overrun_o),
  .dac_data_o   (dac_data_o),
  .result_q     (result_q)
);

// File: tb/test_sample_period_seq.sv
module test_sample_period_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int DW    = 12;
  localparam int RW    = 16;
  localparam int TAPS  = 16;
  localparam int IDX_W = $clog2(TAPS);
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] period = 16'd8;
  logic [DW-1:0]    adc_data = '0;
  logic             adc_ready = 1'b0;
  logic             adc_start_o;
  logic [RW-1:0]    dac_data_o;
  logic             dac_strobe_o;
  logic             eng_start_o;
  logic             eng_done = 1'b0;
  logic [RW-1:0]    eng_result = '0;
  logic [IDX_W-1:0] hist_idx = '0;
  logic [DW-1:0]    hist_data_o;
  logic             overrun_o;

  sample_period_seq i_sample_period_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .period_i     (period),
    .adc_data_i   (adc_data),
    .adc_ready_i  (adc_ready),
    .adc_start_o  (adc_start_o),
    .dac_data_o   (dac_data_o),
    .dac_strobe_o (dac_strobe_o),
    .eng_start_o  (eng_start_o),
    .eng_done_i   (eng_done),
    .eng_result_i (eng_result),
    .hist_idx_i   (hist_idx),
    .hist_data_o  (hist_data_o),
    .overrun_o    (overrun_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int            m_cnt = 0;
  int            m_step = 0;     // 0 idle, 1 out, 2 store, 3 conv, 4 launch, 5 wait
  bit            m_pend = 0;
  bit            m_ovr = 0;
  logic [RW-1:0] m_res = '0;
  logic [RW-1:0] m_dac = '0;
  logic [DW-1:0] m_cap = '0;
  logic [DW-1:0] m_hist[$];
  int            m_lim;
  bit            m_tk;

  task automatic model_clear();
    m_cnt = 0; m_step = 0; m_pend = 0; m_ovr = 0;
    m_res = '0; m_dac = '0; m_cap = '0;
    m_hist.delete();
    for (int i = 0; i < TAPS; i++) m_hist.push_back('0);
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
    end else begin
      m_lim = (period == 0) ? 0 : int'(period) - 1;
      m_tk  = (m_cnt >= m_lim);
      m_cnt = m_tk ? 0 : m_cnt + 1;
      if (m_tk && m_step != 0) begin
        m_pend = 1; m_ovr = 1;
      end
      case (m_step)
        0: if (m_tk || m_pend) begin m_dac = m_res; m_pend = 0; m_step = 1; end
        2: begin m_hist.push_front(m_cap); void'(m_hist.pop_back()); m_step = 3; end
        5: if (eng_done) begin m_res = eng_result; m_step = 0; end
        default: m_step = m_step + 1;
      endcase
      if (adc_ready) m_cap = adc_data;
    end
  end

  // ---------------- stimulus agents and comparison ----------------
  int  cyc = 0;
  int  eng_lat = 1;
  bit  stray = 0;
  bit  eng_busy = 0;
  int  eng_cnt = 0;
  int  adc_cnt = -1;
  logic [15:0] lfsr = 16'hACE1;
  bit  p_dac = 0, p_adc = 0, p_eng = 0;
  string tg;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk({dac_strobe_o, adc_start_o, eng_start_o, overrun_o} == 4'b0, "R9 strobes/flag",
          {dac_strobe_o, adc_start_o, eng_start_o, overrun_o}, 0);
      chk(dac_data_o == '0, "R9 dac_data", dac_data_o, 0);
      chk(hist_data_o == '0, "R9 history", hist_data_o, 0);
    end else begin
      tg = (period == 0) ? "R10 dac_strobe" : "R1 dac_strobe";
      chk(dac_strobe_o == (m_step == 1), tg, dac_strobe_o, m_step == 1);
      chk(adc_start_o == (m_step == 3), "R2 adc_start", adc_start_o, m_step == 3);
      chk(eng_start_o == (m_step == 4), "R2 eng_start", eng_start_o, m_step == 4);
      tg = stray ? "R8 dac_data" : "R3 dac_data";
      chk(dac_data_o == m_dac, tg, dac_data_o, m_dac);
      chk(overrun_o == m_ovr, "R7 overrun", overrun_o, m_ovr);
      tg = (hist_idx == 0) ? "R5 newest sample" : "R4 history";
      chk(hist_data_o == m_hist[hist_idx], tg, hist_data_o, m_hist[hist_idx]);
      if (p_dac || p_adc || p_eng)
        chk(!(p_dac && dac_strobe_o) && !(p_adc && adc_start_o) && !(p_eng && eng_start_o),
            "R6 pulse width", {dac_strobe_o, adc_start_o, eng_start_o}, 0);
    end
    p_dac = dac_strobe_o; p_adc = adc_start_o; p_eng = eng_start_o;

    // drive new inputs
    hist_idx   = IDX_W'(cyc % TAPS);
    eng_result = RW'(cyc * 37 + 5);
    eng_done   = 1'b0;
    adc_ready  = 1'b0;
    if (!rst_n) begin
      eng_busy = 0; adc_cnt = -1;
    end else begin
      if (eng_busy) begin
        if (eng_cnt == 0) begin eng_done = 1'b1; eng_busy = 0; end
        else eng_cnt--;
      end else if (stray && (cyc % 5 == 0)) begin
        eng_done = 1'b1;
      end
      if (eng_start_o) begin eng_busy = 1; eng_cnt = eng_lat; end
      if (adc_cnt == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        adc_data  = lfsr[DW-1:0];
        adc_ready = 1'b1;
      end
      if (adc_cnt >= 0) adc_cnt--;
      if (adc_start_o) adc_cnt = 2;
    end
  end

  task automatic run_phase(input int p, input int lat, input bit str, input int n);
    @(negedge clk); #1;
    period = CNT_W'(p); eng_lat = lat; stray = str;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    run_phase(8, 1, 0, 200);   // R1 R2 R3 R4 R5 R6, fast engine
    run_phase(20, 5, 1, 240);  // R8 stray done pulses
    run_phase(6, 10, 0, 160);  // R7 overrun and held instant
    @(negedge clk); #1 rst_n = 1'b0;   // R9 mid-run reset
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    run_phase(0, 0, 0, 80);    // R10 zero period
    run_phase(1, 0, 0, 80);    // R10 same as period one
    run_phase(3, 2, 0, 80);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule